// File: doc/BRIEF.md
# Retention Cell Test Sequencer

This controller lives in the always-on part of a chip and drives the capture phase of a retention test for one switchable power domain. While scan shift loads and unloads the chains, the domain stays powered and all sequencer controls are quiet. When test control pulses `start`, the sequencer runs a fixed sequence:

1. It raises isolation.
2. It pulses the save strobe so that the flops copy their values into the retention latches.
3. It removes power for a programmable number of cycles.
4. It brings power back and waits a programmable settle time.
5. It pulses the restore strobe.
6. It drops isolation and flags completion.

Scan unload can follow as soon as completion is flagged.

The two interval counts are captured when the run starts, so test control may change them freely while a run is in progress. A count of zero is treated as one cycle. The sequencer does not drive power from any other state, so the domain can only lose power inside the intended off window.

Top module: `ret_test_seq`

## Requirements
- R1: After reset, `pwr_en` is 1 (domain powered) and `iso_en`, `ret_save`, `ret_restore`, `busy` and `done` are all 0.
- R2: When `start` is sampled high while idle, the sequence begins. In the first cycle after that edge, `iso_en` and `busy` are 1. In the second cycle, `ret_save` is 1 for exactly one cycle, with isolation on and power still on.
- R3: `pwr_en` goes to 0 in the cycle after the save pulse. It stays 0 for exactly N cycles, where N is the captured `off_cycles` value, or 1 if that value is 0.
- R4: After power returns, `pwr_en` stays 1 with isolation on for exactly M cycles, where M is the captured `settle_cycles` value, or 1 if that value is 0. `ret_restore` then pulses for exactly one cycle with power on.
- R5: `iso_en` stays 1 from the first busy cycle through the restore cycle. It falls in the cycle after restore, and it is 1 whenever `pwr_en` is 0.
- R6: `busy` is 1 from the first isolation cycle through the restore cycle. `done` is 1 for exactly one cycle, the cycle after restore, and `busy` is 0 in that cycle.
- R7: A `start` that is high while `busy` is 1 is ignored. The run's timing is unchanged, and no new run begins afterwards.
- R8: `off_cycles` and `settle_cycles` are sampled only on the cycle a run is accepted. Changes during a run do not alter that run's intervals.
- R9: `pwr_en` is 0 only within the off interval of R3. It never falls without a save pulse in the previous cycle.
- R10: A `start` sampled in the `done` cycle is accepted, so runs can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on domain |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, accepted only when idle |
| off_cycles | input | OFF_W | Requested power-off duration in cycles |
| settle_cycles | input | SET_W | Requested wait after power-up before restore |
| iso_en | output | 1 | Isolation enable toward the switched domain |
| ret_save | output | 1 | Save strobe to the retention latches |
| pwr_en | output | 1 | Power switch enable, 1 = domain powered |
| ret_restore | output | 1 | Restore strobe to the retention latches |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench sweeps every pairing of small off and settle counts, including zero for each. It compares every control output, cycle by cycle, against a trace computed from those counts. A design that mishandled zero would hang in a wait state or skip the off window altogether. An off-by-one counter would stretch or shorten the window that the retention latches must survive. Further runs keep `start` high throughout, change the counts mid-run, and chain runs off the `done` cycle. These runs expose a sequencer that restarts while busy, rereads its counts, or refuses a request arriving on the completion cycle.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISO     = 3'd1,
    ST_SAVE    = 3'd2,
    ST_OFF     = 3'd3,
    ST_SETTLE  = 3'd4,
    ST_RESTORE = 3'd5
  } rts_state_e;

  typedef struct packed {
    logic iso;
    logic save;
    logic pwr;
    logic rest;
    logic busy;
  } rts_ctl_t;

  function automatic rts_ctl_t rts_decode(input rts_state_e st);
    rts_ctl_t c;
    c = '{iso: 1'b0, save: 1'b0, pwr: 1'b1, rest: 1'b0, busy: 1'b0};
    case (st)
      ST_ISO:     begin c.iso = 1'b1; c.busy = 1'b1; end
      ST_SAVE:    begin c.iso = 1'b1; c.busy = 1'b1; c.save = 1'b1; end
      ST_OFF:     begin c.iso = 1'b1; c.busy = 1'b1; c.pwr = 1'b0; end
      ST_SETTLE:  begin c.iso = 1'b1; c.busy = 1'b1; end
      ST_RESTORE: begin c.iso = 1'b1; c.busy = 1'b1; c.rest = 1'b1; end
      default:    ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rts_timer.sv
module rts_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import rts_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int SET_W = 6,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] off_cfg,
  input  logic [SET_W-1:0] set_cfg,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CW-1:0]    tmr_val,
  output rts_state_e       state_q,
  output rts_state_e       state_d
);

  logic [OFF_W-1:0] off_lat;
  logic [SET_W-1:0] set_lat;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && start;

  // interval counts are frozen at acceptance; zero is clamped to one
  always_ff @(posedge clk) begin
    if (rst) begin
      off_lat <= OFF_W'(1);
      set_lat <= SET_W'(1);
    end else if (accept) begin
      off_lat <= (off_cfg == '0) ? OFF_W'(1) : off_cfg;
      set_lat <= (set_cfg == '0) ? SET_W'(1) : set_cfg;
    end
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_ISO;
      ST_ISO:    state_d = ST_SAVE;
      ST_SAVE: begin
        state_d  = ST_OFF;
        tmr_load = 1'b1;
        tmr_val  = CW'(off_lat) - CW'(1);
      end
      ST_OFF: begin
        if (tmr_expired) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = CW'(set_lat) - CW'(1);
        end
      end
      ST_SETTLE: if (tmr_expired) state_d = ST_RESTORE;
      ST_RESTORE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/rts_outreg.sv
module rts_outreg
  import rts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rts_state_e state_q,
  input  rts_state_e state_d,
  output logic       iso_en,
  output logic       ret_save,
  output logic       pwr_en,
  output logic       ret_restore,
  output logic       busy,
  output logic       done
);

  rts_ctl_t ctl_q;
  rts_ctl_t ctl_d;

  assign ctl_d = rts_decode(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= rts_decode(ST_IDLE);
      done  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      done  <= (state_q == ST_RESTORE) && (state_d == ST_IDLE);
    end
  end

  assign iso_en      = ctl_q.iso;
  assign ret_save    = ctl_q.save;
  assign pwr_en      = ctl_q.pwr;
  assign ret_restore = ctl_q.rest;
  assign busy        = ctl_q.busy;

endmodule

// File: rtl/ret_test_seq.sv
module ret_test_seq
  import rts_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] off_cycles,
  input  logic [SET_W-1:0] settle_cycles,
  output logic             iso_en,
  output logic             ret_save,
  output logic             pwr_en,
  output logic             ret_restore,
  output logic             busy,
  output logic             done
);

  localparam int CW = (OFF_W > SET_W) ? OFF_W : SET_W;

  rts_state_e     state_q;
  rts_state_e     state_d;
  logic           tmr_load;
  logic [CW-1:0]  tmr_val;
  logic           tmr_expired;

  rts_ctrl #(.OFF_W(OFF_W), .SET_W(SET_W), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .off_cfg     (off_cycles),
    .set_cfg     (settle_cycles),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  rts_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  rts_outreg u_out (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .state_d     (state_d),
    .iso_en      (iso_en),
    .ret_save    (ret_save),
    .pwr_en      (pwr_en),
    .ret_restore (ret_restore),
    .busy        (busy),
    .done        (done)
  );

endmodule

// File: rtl/rts_checker.sv
module rts_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic iso_en,
  input logic ret_save,
  input logic pwr_en,
  input logic ret_restore,
  input logic busy,
  input logic done
);

  p_save_guarded_r2: assert property (@(posedge clk) disable iff (rst)
    ret_save |-> (iso_en && $past(iso_en) && pwr_en && busy));

  p_off_after_save_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(ret_save));

  p_restore_powered_r4: assert property (@(posedge clk) disable iff (rst)
    ret_restore |-> (pwr_en && $past(pwr_en) && iso_en));

  p_iso_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> $past(ret_restore));

  p_off_isolated_r5: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> iso_en);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_follows_restore_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ret_restore) && !busy));

  p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ret_save, ret_restore, done}));

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !ret_restore) |=> busy);

  p_power_only_when_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> busy);

  p_idle_accepts_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && iso_en));

endmodule

bind ret_test_seq rts_checker u_rts_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .iso_en      (iso_en),
  .ret_save    (ret_save),
  .pwr_en      (pwr_en),
  .ret_restore (ret_restore),
  .busy        (busy),
  .done        (done)
);

// File: tb/sim_ret_test_seq.sv
`timescale 1ns/1ps
module sim_ret_test_seq;

  localparam int OFF_W = 8;
  localparam int SET_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [OFF_W-1:0] off_cycles = '0;
  logic [SET_W-1:0] settle_cycles = '0;
  logic iso_en, ret_save, pwr_en, ret_restore, busy, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ret_test_seq #(.OFF_W(OFF_W), .SET_W(SET_W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .off_cycles(off_cycles), .settle_cycles(settle_cycles),
    .iso_en(iso_en), .ret_save(ret_save), .pwr_en(pwr_en),
    .ret_restore(ret_restore), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 50000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string name, input logic act, input logic exp, input int c);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s %s at step %0d: actual %b expected %b", req, name, c, act, exp);
    end
  endtask

  // expected {iso, save, pwr, restore, busy, done} at step c after acceptance
  function automatic logic [5:0] expect_at(input int c, input int n, input int m);
    if (c == 1)                     return 6'b101010;
    if (c == 2)                     return 6'b111010;
    if (c >= 3 && c <= n + 2)       return 6'b100010;
    if (c >= n + 3 && c <= n + m + 2) return 6'b101010;
    if (c == n + m + 3)             return 6'b101110;
    if (c == n + m + 4)             return 6'b001001;
    return 6'b001000;
  endfunction

  task automatic compare(input int c, input int n, input int m);
    logic [5:0] e;
    e = expect_at(c, n, m);
    chk("R5", "iso_en",      iso_en,      e[5], c);
    chk("R2", "ret_save",    ret_save,    e[4], c);
    chk("R3/R9", "pwr_en",   pwr_en,      e[3], c);
    chk("R4", "ret_restore", ret_restore, e[2], c);
    chk("R6", "busy",        busy,        e[1], c);
    chk("R6", "done",        done,        e[0], c);
  endtask

  // one run; pre: start already driven by the previous run's done cycle
  task automatic run(input int off_in, input int set_in, input bit noise,
                     input bit change, input bit pre, input bit chain,
                     input int next_off, input int next_set);
    int n;
    int m;
    int last;
    n = (off_in == 0) ? 1 : off_in;
    m = (set_in == 0) ? 1 : set_in;
    if (!pre) begin
      @(negedge clk);
      start = 1'b1;
      off_cycles = OFF_W'(off_in);
      settle_cycles = SET_W'(set_in);
    end
    last = chain ? n + m + 4 : n + m + 6;
    for (int c = 1; c <= last; c++) begin
      @(negedge clk);
      compare(c, n, m);
      start = (noise && c <= n + m + 3) ? 1'b1 : 1'b0;
      if (change && c == 1) begin
        off_cycles = OFF_W'(off_in + 7);   // R8: must not affect this run
        settle_cycles = SET_W'(0);
      end
      if (chain && c == n + m + 4) begin   // R10: request on the done cycle
        start = 1'b1;
        off_cycles = OFF_W'(next_off);
        settle_cycles = SET_W'(next_set);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "iso_en", iso_en, 1'b0, 0);
    chk("R1", "ret_save", ret_save, 1'b0, 0);
    chk("R1", "pwr_en", pwr_en, 1'b1, 0);
    chk("R1", "ret_restore", ret_restore, 1'b0, 0);
    chk("R1", "busy", busy, 1'b0, 0);
    chk("R1", "done", done, 1'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "idle pwr_en", pwr_en, 1'b1, 0);
    chk("R1", "idle busy", busy, 1'b0, 0);

    // R2 R3 R4 R9: sweep all small interval pairs, zero included
    for (int o = 0; o <= 5; o++)
      for (int s = 0; s <= 4; s++)
        run(o, s, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);

    // R7: start held high throughout busy
    run(3, 2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    run(0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    // R8: counts changed mid-run
    run(2, 3, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
    run(4, 1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0);
    // R10: back-to-back runs chained on the done cycle
    run(2, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1, 3);
    run(1, 3, 1'b0, 1'b0, 1'b1, 1'b1, 0, 2);
    run(0, 2, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0);
    // a longer off window
    run(20, 9, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule